// File: doc/BRIEF.md
# Status Flag Register Unit

This block holds a processor's twelve-bit status word and carries out the one-byte flag opcodes. A decoded opcode comes in together with a mask byte and a valid strobe. The opcode can do one of four things. It can set or clear one named flag. It can OR a mask into the low byte of flags, or clear the masked low-byte bits. It can test the low byte against the mask without changing the tested bits, reporting the outcome in the zero and carry flags. A halt opcode sets a sticky halt flag.

Two further sources also write the word. An ALU flag update can write zero, negative, carry and overflow one bit at a time. A flag restore (the pop path) loads the word from a data input. The full word is always visible on an output, which is the save (push) path. The zero, carry and interrupt-enable bits and the halt state also appear on pins of their own.

The opcode, restore and ALU inputs are plain control strobes that are sampled on every rising clock edge. The block never stalls, so there is no ready signal and no back-pressure: every strobe present at an edge is acted on at that edge, and the new word is visible after that edge.

Top module: `status_flag_unit`

## Requirements
- R1: A synchronous active-high `rst` clears all twelve flag bits, so after a reset edge `flags_o` is 0 and `halt_o` is 0.
- R2: With `op_valid` high, opcodes 0xA0 through 0xAA each set one bit, at index (opcode − 0xA0). The bit layout is: 0 zero, 1 negative, 2 carry, 3 overflow, 4 extra, 5 free, 6 bonus, 7 user, 8 debug, 9 interrupt enable, 10 sound interrupt, 11 halt.
- R3: With `op_valid` high, opcodes 0xAB through 0xB5 each clear one bit, at index (opcode − 0xAB), using the same layout.
- R4: Opcode 0xB6 ORs `op_mask` into bits 7:0. Opcode 0xB7 clears each bit of 7:0 that is set in `op_mask`. Bits 11:8 are not affected by either opcode.
- R5: Opcode 0xB8 forms t = flags[7:0] AND `op_mask`, using the word held before the edge. It then sets the zero bit to (t == 0) and the carry bit to (t != 0), and leaves the other ten bits unchanged.
- R6: Opcode 0xFF sets bit 11, and `halt_o` then stays high until reset. The restore path never changes bit 11.
- R7: When `pop_load` is high, bits 10:0 are loaded from `pop_data[10:0]`. `flags_o` always shows the whole current word.
- R8: For each k in 0..3, when `alu_we[k]` is high, bit k takes `alu_val[k]`.
- R9: On a per-bit basis, an opcode that touches a bit wins over the restore path, and the restore path wins over the ALU.
- R10: Other opcode values, and any opcode while `op_valid` is low, leave the word unchanged.
- R11: `flag_z_o`, `flag_c_o` and `flag_i_o` always equal bits 0, 2 and 9 of the word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Opcode strobe |
| op_code | input | 8 | Decoded flag opcode |
| op_mask | input | 8 | Immediate mask byte |
| alu_we | input | 4 | Per-flag ALU write enables (Z,N,C,V) |
| alu_val | input | 4 | ALU flag values (Z,N,C,V) |
| pop_load | input | 1 | Restore strobe |
| pop_data | input | 12 | Word to restore (bit 11 ignored) |
| flags_o | output | 12 | Current flag word (save path) |
| flag_z_o | output | 1 | Zero flag |
| flag_c_o | output | 1 | Carry flag |
| flag_i_o | output | 1 | Interrupt-enable flag |
| halt_o | output | 1 | Halt state |

## Verification
The hardest situation to reach from the ports is a single edge on which all three writers collide. In that edge an opcode, the restore path and ALU enables all name the same bits, and a mask test also reads a word that the ALU is changing in that same cycle. Directed cycles build these collisions on purpose, with the test landing on bits the ALU is overwriting. A long stretch of mixed random cycles then drives all three sources at once, so that the priority rule and the rule that the test reads the old word are both exercised many times.

// File: rtl/sfu_pkg.sv
package sfu_pkg;
  localparam int FLAG_W = 12;
  localparam int LOW_W  = 8;
  localparam int ALU_W  = 4;
  localparam int NAMED  = 11;
  localparam int POP_W  = 11;
  localparam int BIT_Z  = 0;
  localparam int BIT_C  = 2;
  localparam int BIT_I  = 9;
  localparam int BIT_H  = 11;

  localparam logic [7:0] OP_SET_BASE = 8'hA0;
  localparam logic [7:0] OP_CLR_BASE = 8'hAB;
  localparam logic [7:0] OP_SETM     = 8'hB6;
  localparam logic [7:0] OP_CLRM     = 8'hB7;
  localparam logic [7:0] OP_TESTM    = 8'hB8;
  localparam logic [7:0] OP_HALT     = 8'hFF;

  typedef struct packed {
    logic [FLAG_W-1:0] set;
    logic [FLAG_W-1:0] clr;
  } flag_cmd_t;
endpackage

// File: rtl/sfu_decode.sv
module sfu_decode
  import sfu_pkg::*;
(
  input  logic             valid,
  input  logic [7:0]       code,
  input  logic [LOW_W-1:0] mask,
  output flag_cmd_t        cmd,
  output logic             test_en
);
  always_comb begin
    cmd     = '0;
    test_en = 1'b0;
    if (valid) begin
      for (int k = 0; k < NAMED; k++) begin
        if (code == OP_SET_BASE + 8'(k)) cmd.set[k] = 1'b1;
        if (code == OP_CLR_BASE + 8'(k)) cmd.clr[k] = 1'b1;
      end
      case (code)
        OP_SETM:  cmd.set[LOW_W-1:0] = mask;
        OP_CLRM:  cmd.clr[LOW_W-1:0] = mask;
        OP_TESTM: test_en = 1'b1;
        OP_HALT:  cmd.set[BIT_H] = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/sfu_tester.sv
module sfu_tester
  import sfu_pkg::*;
(
  input  logic             en,
  input  logic [LOW_W-1:0] low_flags,
  input  logic [LOW_W-1:0] mask,
  output flag_cmd_t        cmd
);
  logic any_hit;
  assign any_hit = |(low_flags & mask);

  always_comb begin
    cmd = '0;
    if (en) begin
      cmd.set[BIT_Z] = ~any_hit;
      cmd.clr[BIT_Z] = any_hit;
      cmd.set[BIT_C] = any_hit;
      cmd.clr[BIT_C] = ~any_hit;
    end
  end
endmodule

// File: rtl/sfu_merge.sv
module sfu_merge
  import sfu_pkg::*;
(
  input  logic [FLAG_W-1:0] cur,
  input  flag_cmd_t         cmd,
  input  logic              pop_en,
  input  logic [FLAG_W-1:0] pop_word,
  input  logic [ALU_W-1:0]  alu_we,
  input  logic [ALU_W-1:0]  alu_val,
  output logic [FLAG_W-1:0] nxt
);
  for (genvar b = 0; b < FLAG_W; b++) begin : g_bit
    logic touched;
    logic below;
    assign touched = cmd.set[b] | cmd.clr[b];
    if (b < ALU_W) begin : g_alu
      always_comb begin
        if (alu_we[b]) below = alu_val[b];
        else           below = cur[b];
      end
    end else begin : g_noalu
      assign below = cur[b];
    end
    if (b < POP_W) begin : g_pop
      assign nxt[b] = touched ? cmd.set[b] : (pop_en ? pop_word[b] : below);
    end else begin : g_nopop
      assign nxt[b] = touched ? cmd.set[b] : below;
    end
  end
endmodule

// File: rtl/status_flag_unit.sv
module status_flag_unit
  import sfu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  input  logic [7:0]        op_code,
  input  logic [LOW_W-1:0]  op_mask,
  input  logic [ALU_W-1:0]  alu_we,
  input  logic [ALU_W-1:0]  alu_val,
  input  logic              pop_load,
  input  logic [FLAG_W-1:0] pop_data,
  output logic [FLAG_W-1:0] flags_o,
  output logic              flag_z_o,
  output logic              flag_c_o,
  output logic              flag_i_o,
  output logic              halt_o
);
  logic [FLAG_W-1:0] flags_q;
  logic [FLAG_W-1:0] flags_d;
  flag_cmd_t         dec_cmd;
  flag_cmd_t         tst_cmd;
  flag_cmd_t         all_cmd;
  logic              test_en;

  sfu_decode u_dec (
    .valid(op_valid), .code(op_code), .mask(op_mask),
    .cmd(dec_cmd), .test_en(test_en)
  );

  sfu_tester u_tst (
    .en(test_en), .low_flags(flags_q[LOW_W-1:0]), .mask(op_mask), .cmd(tst_cmd)
  );

  assign all_cmd.set = dec_cmd.set | tst_cmd.set;
  assign all_cmd.clr = dec_cmd.clr | tst_cmd.clr;

  sfu_merge u_mrg (
    .cur(flags_q), .cmd(all_cmd), .pop_en(pop_load), .pop_word(pop_data),
    .alu_we(alu_we), .alu_val(alu_val), .nxt(flags_d)
  );

  always_ff @(posedge clk) begin
    if (rst) flags_q <= '0;
    else     flags_q <= flags_d;
  end

  assign flags_o  = flags_q;
  assign flag_z_o = flags_q[BIT_Z];
  assign flag_c_o = flags_q[BIT_C];
  assign flag_i_o = flags_q[BIT_I];
  assign halt_o   = flags_q[BIT_H];

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (flags_o == '0 && !halt_o)); // R1
  AST_SET_CARRY: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 8'hA2) |=> flag_c_o); // R2
  AST_CLR_IE: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == 8'hB4) |=> !flag_i_o); // R3
  AST_MASK_SET: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SETM) |=> ((flags_o[LOW_W-1:0] & $past(op_mask)) == $past(op_mask))); // R4
  AST_MASK_CLR: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_CLRM) |=> ((flags_o[LOW_W-1:0] & $past(op_mask)) == '0)); // R4
  AST_TEST_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_TESTM && !pop_load && alu_we == '0)
    |=> (flags_o[FLAG_W-1:3] == $past(flags_o[FLAG_W-1:3]) && flags_o[1] == $past(flags_o[1]))); // R5
  AST_TEST_ZC: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_TESTM) |=> (flag_z_o != flag_c_o)); // R5
  AST_HALT_STICKY: assert property (@(posedge clk) disable iff (rst)
    halt_o |=> halt_o); // R6
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!op_valid && !pop_load && alu_we == '0) |=> $stable(flags_o)); // R10
endmodule

// File: tb/status_flag_unit_tb.sv
module status_flag_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic [7:0]  op_code = 8'h00;
  logic [7:0]  op_mask = 8'h00;
  logic [3:0]  alu_we = 4'h0;
  logic [3:0]  alu_val = 4'h0;
  logic        pop_load = 1'b0;
  logic [11:0] pop_data = 12'h000;
  logic [11:0] flags_o;
  logic        flag_z_o, flag_c_o, flag_i_o, halt_o;

  int checks = 0;
  int fails  = 0;
  logic [11:0] expw = 12'h000;

  always #2 clk = ~clk;

  status_flag_unit u_dut (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .op_mask(op_mask),
    .alu_we(alu_we), .alu_val(alu_val), .pop_load(pop_load), .pop_data(pop_data),
    .flags_o(flags_o), .flag_z_o(flag_z_o), .flag_c_o(flag_c_o),
    .flag_i_o(flag_i_o), .halt_o(halt_o)
  );

  function automatic logic [11:0] ref_next(logic [11:0] cur, logic v, logic [7:0] op,
      logic [7:0] m, logic pl, logic [11:0] pd, logic [3:0] awe, logic [3:0] aval);
    logic [11:0] n;
    logic [7:0]  t;
    int code;
    n = cur;
    code = int'(op);
    for (int k = 0; k < 4; k++) if (awe[k]) n[k] = aval[k];
    if (pl) n[10:0] = pd[10:0];
    if (v) begin
      if (code >= 160 && code <= 170) n[code-160] = 1'b1;
      else if (code >= 171 && code <= 181) n[code-171] = 1'b0;
      else if (code == 182) n[7:0] = n[7:0] | m;
      else if (code == 183) n[7:0] = n[7:0] & ~m;
      else if (code == 184) begin
        t = cur[7:0] & m;
        n[0] = (t == 8'h00);
        n[2] = (t != 8'h00);
      end else if (code == 255) n[11] = 1'b1;
    end
    return n;
  endfunction

  task automatic compare(string req);
    logic [14:0] got, want;
    got  = {flags_o, flag_z_o, flag_c_o, flag_i_o};
    want = {expw, expw[0], expw[2], expw[9]};
    checks++;
    if (got !== want || halt_o !== expw[11]) begin
      fails++;
      $display("FAIL %s: flags=%03h z/c/i=%b%b%b halt=%b expected flags=%03h halt=%b",
               req, flags_o, flag_z_o, flag_c_o, flag_i_o, halt_o, expw, expw[11]);
    end
  endtask

  task automatic step(string req, logic v, logic [7:0] op, logic [7:0] m,
                      logic pl, logic [11:0] pd, logic [3:0] awe, logic [3:0] aval);
    op_valid = v; op_code = op; op_mask = m;
    pop_load = pl; pop_data = pd; alu_we = awe; alu_val = aval;
    expw = rst ? 12'h000 : ref_next(expw, v, op, m, pl, pd, awe, aval);
    @(posedge clk);
    @(negedge clk);
    compare(req);
  endtask

  task automatic opc(string req, logic [7:0] op, logic [7:0] m);
    step(req, 1'b1, op, m, 1'b0, 12'h000, 4'h0, 4'h0);
  endtask

  task automatic idle(string req);
    step(req, 1'b0, 8'h00, 8'h00, 1'b0, 12'h000, 4'h0, 4'h0);
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    finish_run();
  end

  initial begin
    @(negedge clk);
    step("R1", 1'b1, 8'hFF, 8'hFF, 1'b1, 12'hFFF, 4'hF, 4'hF);
    rst = 1'b0;
    idle("R1");
    // R2 each named set, R11 taps
    for (int k = 0; k < 11; k++) opc("R2", 8'(8'hA0 + k), 8'h00);
    if (flags_o != 12'h7FF) begin fails++; $display("FAIL R2: flags=%03h expected 7ff", flags_o); end
    checks++;
    // R3 each named clear
    for (int k = 0; k < 11; k++) opc("R3", 8'(8'hAB + k), 8'h00);
    opc("R11", 8'hA9, 8'h00);
    opc("R11", 8'hA2, 8'h00);
    // R4 mask set/clear
    opc("R4", 8'hB6, 8'h5A);
    opc("R4", 8'hB6, 8'h81);
    opc("R4", 8'hB7, 8'h0F);
    opc("R4", 8'hB7, 8'hFF);
    // R5 test: hit and miss
    opc("R4", 8'hB6, 8'h30);
    opc("R5", 8'hB8, 8'h10);
    opc("R5", 8'hB8, 8'h0C);
    opc("R5", 8'hB8, 8'h00);
    // R5 test reads old word while ALU writes zero/carry
    step("R5", 1'b1, 8'hB8, 8'h20, 1'b0, 12'h000, 4'h5, 4'h5);
    // R7 restore and R10 ignored opcodes
    step("R7", 1'b0, 8'h00, 8'h00, 1'b1, 12'hA5C, 4'h0, 4'h0);
    opc("R10", 8'h9F, 8'hFF);
    opc("R10", 8'hB9, 8'hFF);
    step("R10", 1'b0, 8'hA0, 8'hFF, 1'b0, 12'h000, 4'h0, 4'h0);
    // R8 ALU writes
    step("R8", 1'b0, 8'h00, 8'h00, 1'b0, 12'h000, 4'hF, 4'hA);
    step("R8", 1'b0, 8'h00, 8'h00, 1'b0, 12'h000, 4'h6, 4'h0);
    // R9 collisions
    step("R9", 1'b1, 8'hA2, 8'h00, 1'b1, 12'h000, 4'hF, 4'h0);
    step("R9", 1'b1, 8'hB7, 8'h01, 1'b1, 12'h7FF, 4'hF, 4'hF);
    step("R9", 1'b0, 8'h00, 8'h00, 1'b1, 12'h005, 4'hF, 4'hA);
    // R6 halt sticky, restore cannot clear
    opc("R6", 8'hFF, 8'h00);
    step("R6", 1'b0, 8'h00, 8'h00, 1'b1, 12'h000, 4'h0, 4'h0);
    opc("R6", 8'hB7, 8'hFF);
    // mixed random traffic
    for (int i = 0; i < 2000; i++) begin
      logic [7:0] op;
      int sel;
      sel = int'($urandom_range(0, 19));
      if (sel < 16) op = 8'(8'hA0 + $urandom_range(0, 24));
      else if (sel < 19) op = 8'($urandom_range(0, 255));
      else op = 8'hFF;
      if (i % 500 == 0) begin
        rst = 1'b1; idle("R1"); rst = 1'b0;
      end
      step("R9", 1'($urandom_range(0, 3) != 0), op, 8'($urandom),
           1'($urandom_range(0, 4) == 0), 12'($urandom), 4'($urandom), 4'($urandom));
    end
    rst = 1'b1;
    idle("R1");
    rst = 1'b0;
    idle("R10");
    finish_run();
  end
endmodule